// File: doc/BRIEF.md
# Victim Line Buffer

A small fully associative store that sits between a direct-mapped cache and the path that refills it. It only ever receives lines that the cache throws out on replacement. Each slot keeps a valid bit, the whole line address, a dirty flag and the line payload. When the cache misses, it presents the wanted line address together with the line it is about to displace. The buffer answers one cycle later.

On a buffer hit the stored line goes back to the cache and the displaced line takes the freed slot, so the two lines trade places. On a buffer miss a read request for the wanted address goes to the next memory level, and the displaced line is stored. If no slot is free, the least recently used slot is overwritten. When that slot is dirty, its contents are first offered on a write-back port, and the buffer stalls until the write-back is accepted.

The controller is a three-state machine:
- S_IDLE waits for a request. It moves to S_RESP when `lk_req` is seen while `ready` is high.
- S_RESP presents the result. It moves to S_WB when an insert must push out a dirty line, and otherwise returns to S_IDLE.
- S_WB holds the write-back request. It returns to S_IDLE on `wb_ack`, writing the insert in that same cycle.

Top module: `victim_buffer`

## Requirements
- R1: After reset every slot is empty, `ready` is 1, and `rsp_valid`, `nl_rd_req` and `wb_req` are 0.
- R2: A request accepted at a clock edge (`lk_req` high while `ready` is high) gives `rsp_valid` high during the following cycle only.
- R3: The response reports a hit (`rsp_hit`=1) exactly when a valid slot holds the requested line address. On a hit, `rsp_data` is that slot's payload.
- R4: On a hit the returned line leaves the buffer and the displaced line (when `vic_valid`=1) takes its slot. A later lookup of the returned address misses, and a lookup of the displaced address hits.
- R5: On a miss, `nl_rd_req` is high for the response cycle only, with `nl_rd_addr` equal to the requested address. It is never high on a hit.
- R6: On a miss with `vic_valid`=1, the displaced line is stored. The lowest-numbered empty slot is used first.
- R7: With no empty slot, the least recently used slot is replaced. Both a hit and an insert make the affected slot the most recently used.
- R8: Replacing a dirty slot raises `wb_req` with that slot's address and payload. `wb_req` and `wb_addr` stay steady and `ready` stays 0 until `wb_ack`. Replacing a clean slot raises no `wb_req`.
- R9: The dirty flag travels with a line: `rsp_dirty` on a hit equals the `vic_dirty` value given when the line was stored.
- R10: A missed address is never stored by the miss itself. Only lines given as displaced enter the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ready | output | 1 | High when a request can be accepted (S_IDLE) |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | AW | Requested line address |
| vic_valid | input | 1 | A displaced line accompanies the request |
| vic_addr | input | AW | Displaced line address |
| vic_dirty | input | 1 | Displaced line is modified |
| vic_data | input | DW | Displaced line payload |
| rsp_valid | output | 1 | Result cycle |
| rsp_hit | output | 1 | Requested line found |
| rsp_dirty | output | 1 | Dirty flag of the returned line |
| rsp_data | output | DW | Returned line payload |
| nl_rd_req | output | 1 | Next-level read request |
| nl_rd_addr | output | AW | Next-level read address |
| wb_req | output | 1 | Write-back request |
| wb_ack | input | 1 | Write-back accepted |
| wb_addr | output | AW | Write-back line address |
| wb_data | output | DW | Write-back payload |

## Verification
The bench builds the block with 4 slots, 6-bit line addresses and 8-bit payloads. With those sizes a full sweep of all 64 addresses, with every displaced line chosen arithmetically, fits in a few hundred operations. That sweep reaches every slot in every age position many times, and it forces both clean and dirty replacements with write-back accept delays of zero to two cycles. Directed phases come first: a fill, a swap round and a repeated miss. They pin down the free-slot order, the exclusivity after a swap, and the rule that missed addresses are never stored.

// File: rtl/vb_pkg.sv
package vb_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RESP = 2'd1,
        S_WB   = 2'd2
    } vb_state_e;
endpackage

// File: rtl/vb_match.sv
module vb_match #(
    parameter int N  = 4,
    parameter int AW = 26,
    localparam int IW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         valid,
    input  logic [N-1:0][AW-1:0] addrs,
    input  logic [AW-1:0]        key,
    output logic                 hit,
    output logic [IW-1:0]        hit_idx
);
    logic [N-1:0] hit_vec;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (addrs[g] == key);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IW'(i);
        end
    end

    assign hit = |hit_vec;

    // R3: a line address is held by at most one slot
    p_single_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/vb_lru.sv
module vb_lru #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch,
    input  logic [IW-1:0] touch_idx,
    input  logic [N-1:0]  valid,
    output logic [IW-1:0] sel_idx
);
    logic [IW-1:0] age [N];
    logic [N-1:0]  oldest_vec;
    logic [IW-1:0] oldest_idx;
    logic [IW-1:0] free_idx;
    logic          has_free;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age[i] <= IW'(i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx) age[i] <= '0;
                else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_old
        assign oldest_vec[g] = (age[g] == IW'(N - 1));
    end

    always_comb begin
        oldest_idx = '0;
        free_idx   = '0;
        has_free   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (oldest_vec[i]) oldest_idx = IW'(i);
            if (!valid[i]) begin
                free_idx = IW'(i);
                has_free = 1'b1;
            end
        end
        sel_idx = has_free ? free_idx : oldest_idx;
    end

    // R7: ages stay a permutation, so exactly one slot is oldest
    p_one_oldest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1);
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
    import vb_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 26,
    parameter int DW = 128,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          ready,
    input  logic          lk_req,
    input  logic [AW-1:0] lk_addr,
    input  logic          vic_valid,
    input  logic [AW-1:0] vic_addr,
    input  logic          vic_dirty,
    input  logic [DW-1:0] vic_data,
    output logic          rsp_valid,
    output logic          rsp_hit,
    output logic          rsp_dirty,
    output logic [DW-1:0] rsp_data,
    output logic          nl_rd_req,
    output logic [AW-1:0] nl_rd_addr,
    output logic          wb_req,
    input  logic          wb_ack,
    output logic [AW-1:0] wb_addr,
    output logic [DW-1:0] wb_data
);
    vb_state_e state, state_nx;

    logic [N-1:0]         e_valid;
    logic [N-1:0]         e_dirty;
    logic [N-1:0][AW-1:0] e_addr;
    logic [DW-1:0]        e_data [N];

    logic [AW-1:0] q_addr;
    logic          q_vvalid;
    logic [AW-1:0] q_vaddr;
    logic          q_vdirty;
    logic [DW-1:0] q_vdata;
    logic [IW-1:0] ins_q;

    logic          hit;
    logic [IW-1:0] hit_idx;
    logic [IW-1:0] sel_idx;
    logic          need_wb;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic          accept;

    vb_match #(.N(N), .AW(AW)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (e_valid),
        .addrs   (e_addr),
        .key     (q_addr),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    vb_lru #(.N(N)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (wr_en),
        .touch_idx (wr_idx),
        .valid     (e_valid),
        .sel_idx   (sel_idx)
    );

    assign accept  = (state == S_IDLE) && lk_req;
    assign need_wb = !hit && q_vvalid && e_valid[sel_idx] && e_dirty[sel_idx];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (lk_req) state_nx = S_RESP;
            S_RESP: state_nx = need_wb ? S_WB : S_IDLE;
            S_WB:   if (wb_ack) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs and slot write control
    always_comb begin
        ready      = 1'b0;
        rsp_valid  = 1'b0;
        rsp_hit    = 1'b0;
        rsp_dirty  = 1'b0;
        rsp_data   = '0;
        nl_rd_req  = 1'b0;
        nl_rd_addr = q_addr;
        wb_req     = 1'b0;
        wb_addr    = e_addr[ins_q];
        wb_data    = e_data[ins_q];
        wr_en      = 1'b0;
        wr_idx     = sel_idx;
        unique case (state)
            S_IDLE: ready = 1'b1;
            S_RESP: begin
                rsp_valid = 1'b1;
                rsp_hit   = hit;
                if (hit) begin
                    rsp_dirty = e_dirty[hit_idx];
                    rsp_data  = e_data[hit_idx];
                    wr_en     = 1'b1;
                    wr_idx    = hit_idx;
                end else begin
                    nl_rd_req = 1'b1;
                    wr_en     = q_vvalid && !need_wb;
                end
            end
            S_WB: begin
                wb_req = 1'b1;
                wr_en  = wb_ack;
                wr_idx = ins_q;
            end
            default: ;
        endcase
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_addr   <= '0;
            q_vvalid <= 1'b0;
            q_vaddr  <= '0;
            q_vdirty <= 1'b0;
            q_vdata  <= '0;
            ins_q    <= '0;
        end else begin
            if (accept) begin
                q_addr   <= lk_addr;
                q_vvalid <= vic_valid;
                q_vaddr  <= vic_addr;
                q_vdirty <= vic_dirty;
                q_vdata  <= vic_data;
            end
            if (state == S_RESP) ins_q <= sel_idx;
        end
    end

    // slot storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_valid <= '0;
            e_dirty <= '0;
            e_addr  <= '0;
            for (int i = 0; i < N; i++) e_data[i] <= '0;
        end else if (wr_en) begin
            e_valid[wr_idx] <= q_vvalid;
            e_dirty[wr_idx] <= q_vdirty;
            e_addr[wr_idx]  <= q_vaddr;
            e_data[wr_idx]  <= q_vdata;
        end
    end

    p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && lk_req) |=> rsp_valid);

    p_rdreq_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        nl_rd_req |-> (rsp_valid && !rsp_hit));

    p_wb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)));

    p_wb_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> !ready);
endmodule

// File: tb/victim_buffer_test.sv
module victim_buffer_test;
    localparam int N  = 4;
    localparam int AW = 6;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ready;
    logic          lk_req = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          vic_valid = 1'b0;
    logic [AW-1:0] vic_addr = '0;
    logic          vic_dirty = 1'b0;
    logic [DW-1:0] vic_data = '0;
    logic          rsp_valid, rsp_hit, rsp_dirty;
    logic [DW-1:0] rsp_data;
    logic          nl_rd_req;
    logic [AW-1:0] nl_rd_addr;
    logic          wb_req;
    logic          wb_ack = 1'b0;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_data;

    int total = 0;
    int bad   = 0;

    // reference model
    logic          m_valid [N];
    logic          m_dirty [N];
    logic [AW-1:0] m_addr  [N];
    logic [DW-1:0] m_data  [N];
    int            m_age   [N];

    always #10 clk = ~clk;

    victim_buffer #(.N(N), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .ready(ready),
        .lk_req(lk_req), .lk_addr(lk_addr),
        .vic_valid(vic_valid), .vic_addr(vic_addr),
        .vic_dirty(vic_dirty), .vic_data(vic_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_dirty(rsp_dirty), .rsp_data(rsp_data),
        .nl_rd_req(nl_rd_req), .nl_rd_addr(nl_rd_addr),
        .wb_req(wb_req), .wb_ack(wb_ack),
        .wb_addr(wb_addr), .wb_data(wb_data)
    );

    task automatic chk(input string rq, input string what,
                       input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pay(input int a);
        return DW'(a * 37 + 11);
    endfunction

    function automatic int m_find(input logic [AW-1:0] a);
        for (int i = 0; i < N; i++) if (m_valid[i] && m_addr[i] == a) return i;
        return -1;
    endfunction

    function automatic int m_pick();
        for (int i = 0; i < N; i++) if (!m_valid[i]) return i;
        for (int i = 0; i < N; i++) if (m_age[i] == N - 1) return i;
        return 0;
    endfunction

    task automatic m_touch(input int s);
        int old = m_age[s];
        for (int i = 0; i < N; i++) begin
            if (i == s) m_age[i] = 0;
            else if (m_age[i] < old) m_age[i] = m_age[i] + 1;
        end
    endtask

    // one lookup with an optional displaced line; rq tags the checks
    task automatic do_op(input string rq, input logic [AW-1:0] a,
                         input logic vv, input logic [AW-1:0] va,
                         input logic vd, input int ack_dly);
        int h, s;
        logic e_wb;
        logic v;
        v = vv;
        if (v && (m_find(va) >= 0 || va == a)) v = 1'b0;
        h = m_find(a);
        s = (h >= 0) ? h : m_pick();
        e_wb = (h < 0) && v && m_valid[s] && m_dirty[s];
        while (!ready) @(negedge clk);
        lk_req = 1'b1; lk_addr = a; vic_valid = v;
        vic_addr = va; vic_dirty = vd; vic_data = pay(va);
        @(posedge clk);
        @(negedge clk);
        lk_req = 1'b0;
        chk("R2", "rsp_valid", int'(rsp_valid), 1);
        chk("R3", "rsp_hit", int'(rsp_hit), int'(h >= 0));
        chk("R5", "nl_rd_req", int'(nl_rd_req), int'(h < 0));
        if (h >= 0) begin
            chk("R3", "rsp_data", int'(rsp_data), int'(m_data[h]));
            chk("R9", "rsp_dirty", int'(rsp_dirty), int'(m_dirty[h]));
        end else begin
            chk("R5", "nl_rd_addr", int'(nl_rd_addr), int'(a));
        end
        @(negedge clk);
        if (e_wb) begin
            chk("R8", "wb_req", int'(wb_req), 1);
            chk("R8", "ready during wb", int'(ready), 0);
            chk("R8", "wb_addr", int'(wb_addr), int'(m_addr[s]));
            chk("R8", "wb_data", int'(wb_data), int'(m_data[s]));
            for (int k = 0; k < ack_dly; k++) begin
                @(negedge clk);
                chk("R8", "wb_req held", int'(wb_req), 1);
            end
            wb_ack = 1'b1;
            @(negedge clk);
            wb_ack = 1'b0;
        end else begin
            chk("R8", "no wb_req", int'(wb_req), 0);
            chk("R2", "rsp one cycle", int'(rsp_valid), 0);
        end
        if (h >= 0 || v) begin
            m_valid[s] = v;
            m_addr[s]  = va;
            m_dirty[s] = vd;
            m_data[s]  = pay(va);
            m_touch(s);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 1'b0; m_dirty[i] = 1'b0;
            m_addr[i] = '0; m_data[i] = '0; m_age[i] = i;
        end
        repeat (3) @(negedge clk);
        chk("R1", "ready", int'(ready), 1);
        chk("R1", "rsp_valid", int'(rsp_valid), 0);
        chk("R1", "nl_rd_req", int'(nl_rd_req), 0);
        chk("R1", "wb_req", int'(wb_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after release", int'(ready), 1);

        // R6: fill empty slots with displaced lines 0..3
        for (int i = 0; i < N; i++)
            do_op("R6", AW'(40 + i), 1'b1, AW'(i), i[0], 0);
        // R10: a missed address was not stored
        do_op("R10", AW'(40), 1'b0, '0, 1'b0, 0);
        // R4: swaps, then returned lines are gone, displaced ones present
        for (int i = 0; i < N; i++)
            do_op("R4", AW'(i), 1'b1, AW'(8 + i), ~i[0], 0);
        do_op("R4", AW'(0), 1'b0, '0, 1'b0, 0);
        do_op("R4", AW'(9), 1'b1, AW'(20), 1'b1, 0);
        // R7/R8: pressure with mixed dirty lines
        for (int k = 0; k < 24; k++)
            do_op("R7", AW'(k % 12), 1'b1, AW'(16 + k), k[0], k % 3);
        // sweep every address
        for (int a = 0; a < 64; a++)
            do_op("R8", AW'(a), 1'b1, AW'((a * 5 + 3) % 64), a[1], a % 3);
        for (int a = 0; a < 64; a++)
            do_op("R3", AW'((a * 7) % 64), 1'b1, AW'(63 - a), a[0], 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule